// File: doc/BRIEF.md
# Sectored flash write-protection unit

This block sits between a CPU register bus and an embedded flash controller and decides whether each program or erase request may go ahead. It holds two 16-bit section-enable registers and an 8-bit flash control register. The first enable register covers a 128 KB program-flash window cut into 8 KB sections. The second covers an 8 KB data-flash window cut into 512-byte sections. After reset every enable bit is clear, so the whole array is locked until software opens individual sections.

Each request carries an operation code and a byte address. The address is matched against both windows, and a section index is taken from the bits just above the section size. The request is granted only if the enable bit for that section is set. A mass erase is allowed only when every program-flash section is open. The decision is registered and comes back one clock after the strobe, with a done pulse. Any denial sets a sticky violation flag, which software clears by writing 1 to it.

The control register's low-power bit is frozen while the flash controller reports busy. The other control bits still accept writes during that time.

Top module: `flash_guard`

## Requirements
- R1: After reset the program enables, data enables, control register and violation flag all read as zero, so every section is protected.
- R2: Operations 0 (program) and 1 (page erase) at addresses 0x020000–0x03FFFF use section index addr[16:13]. The request is granted exactly when bit index of the program enable register is 1.
- R3: Operations 0 and 1 at addresses 0x0D0000–0x0D1FFF use section index addr[12:9]. The request is granted exactly when bit index of the data enable register is 1.
- R4: Operations 0 and 1 at addresses outside both windows are denied. Operation code 3 is always denied.
- R5: Operation 2 (mass erase) is granted only when the program enable register reads 16'hFFFF. Its address is ignored.
- R6: The grant or deny decision appears on req_grant one clock after a req_valid strobe. req_done is high for exactly that one cycle, and req_grant is never high without req_done.
- R7: Every denial sets the violation flag (status register bit 0, also driven on prot_fault). The flag stays set until a bus write to the status register with bit 0 = 1. If a denial and a clear happen in the same cycle, the flag stays set.
- R8: Register select 0 is the program enable register, 1 is the data enable register, 2 is the control register (bits 7:0, upper bits read 0) and 3 is the status register. Registers 0 to 2 are readable and writable on the bus.
- R9: Control bits 5 and 1 are reserved. They always read 0 and ignore writes. The writable control bits are 7, 6, 4, 3, 2 and 0.
- R10: While flash_busy is 1, writes cannot change control bit 0 (low-power mode), but the other writable control bits still update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register (combinational) |
| flash_busy | input | 1 | Flash controller is programming or erasing |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | Operation: 0 program, 1 page erase, 2 mass erase, 3 none |
| req_addr | input | 24 | Byte address of the request |
| req_done | output | 1 | Decision valid pulse, one cycle after the strobe |
| req_grant | output | 1 | Request allowed (valid with req_done) |
| prot_fault | output | 1 | Sticky violation flag |

## Verification
The bench builds the block with its default parameters: 24-bit addresses, 16 sections per window, window bases 0x020000 and 0x0D0000, and section sizes of 8 KB and 512 bytes. With these values the first, last and neighbouring sections of both windows, and the bytes just outside each window, can all be reached with a handful of addresses. The section-size parameters put the index fields at different bit positions, so a mix-up between the two decoders shows up as a wrong grant.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_PAGE = 2'd1,
    OP_MASS = 2'd2,
    OP_NONE = 2'd3
  } flash_op_e;

  typedef enum logic [1:0] {
    SEL_PGM  = 2'd0,
    SEL_DAT  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  localparam int          CTRL_W       = 8;
  localparam int          CTRL_LP_BIT  = 0;
  localparam logic [7:0]  CTRL_RW_MASK = 8'hDD;

endpackage

// File: rtl/flash_guard_decode.sv
module flash_guard_decode #(
  parameter int                ADDR_W   = 24,
  parameter int                SEC_CNT  = 16,
  parameter int                SEC_LOG2 = 13,
  parameter logic [ADDR_W-1:0] BASE     = 24'h020000
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [SEC_CNT-1:0] sec_we,
  output logic               hit,
  output logic               allowed
);

  localparam int IDX_W   = $clog2(SEC_CNT);
  localparam int TOP_LSB = SEC_LOG2 + IDX_W;

  logic [IDX_W-1:0] idx;

  always_comb begin
    idx     = addr[TOP_LSB-1:SEC_LOG2];
    hit     = (addr[ADDR_W-1:TOP_LSB] == BASE[ADDR_W-1:TOP_LSB]);
    allowed = hit && sec_we[idx];
  end

endmodule

// File: rtl/flash_guard_regs.sv
module flash_guard_regs
  import flash_guard_pkg::*;
#(
  parameter int SEC_CNT = 16,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         bus_sel,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               flash_busy,
  input  logic               viol_set,
  output logic [SEC_CNT-1:0] pgm_we,
  output logic [SEC_CNT-1:0] dat_we,
  output logic               viol
);

  logic [SEC_CNT-1:0] pgm_q, pgm_d, dat_q, dat_d;
  logic [CTRL_W-1:0]  ctrl_q, ctrl_d;
  logic               viol_q, viol_d;
  logic               wr_pgm, wr_dat, wr_ctrl, wr_stat;

  always_comb begin
    wr_pgm  = bus_wr && (bus_sel == SEL_PGM);
    wr_dat  = bus_wr && (bus_sel == SEL_DAT);
    wr_ctrl = bus_wr && (bus_sel == SEL_CTRL);
    wr_stat = bus_wr && (bus_sel == SEL_STAT);

    pgm_d = wr_pgm ? bus_wdata[SEC_CNT-1:0] : pgm_q;
    dat_d = wr_dat ? bus_wdata[SEC_CNT-1:0] : dat_q;

    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d = bus_wdata[CTRL_W-1:0] & CTRL_RW_MASK;
      if (flash_busy) ctrl_d[CTRL_LP_BIT] = ctrl_q[CTRL_LP_BIT];
    end

    viol_d = viol_q;
    if (viol_set)                    viol_d = 1'b1;
    else if (wr_stat && bus_wdata[0]) viol_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pgm_q  <= '0;
      dat_q  <= '0;
      ctrl_q <= '0;
      viol_q <= 1'b0;
    end else begin
      if (wr_pgm)  pgm_q  <= pgm_d;
      if (wr_dat)  dat_q  <= dat_d;
      if (wr_ctrl) ctrl_q <= ctrl_d;
      viol_q <= viol_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_sel)
      SEL_PGM:  bus_rdata[SEC_CNT-1:0] = pgm_q;
      SEL_DAT:  bus_rdata[SEC_CNT-1:0] = dat_q;
      SEL_CTRL: bus_rdata[CTRL_W-1:0]  = ctrl_q;
      default:  bus_rdata[0]           = viol_q;
    endcase
  end

  assign pgm_we = pgm_q;
  assign dat_we = dat_q;
  assign viol   = viol_q;

  // R10: low-power bit frozen across a busy cycle
  a_r10_lp_locked: assert property (@(posedge clk) disable iff (!rst_n)
    flash_busy |=> ctrl_q[CTRL_LP_BIT] == $past(ctrl_q[CTRL_LP_BIT]));

  // R7: flag only falls on an explicit clear
  a_r7_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q && !(wr_stat && bus_wdata[0]) |=> viol_q);

  // R9: reserved control bits never read back as 1
  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == SEL_CTRL) |-> (bus_rdata[5] == 1'b0 && bus_rdata[1] == 1'b0));

endmodule

// File: rtl/flash_guard_arb.sv
module flash_guard_arb
  import flash_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_kind,
  input  logic       pgm_ok,
  input  logic       dat_ok,
  input  logic       pgm_all,
  output logic       viol_set,
  output logic       done,
  output logic       grant
);

  logic allow_c, done_q, grant_q;

  always_comb begin
    unique case (req_kind)
      OP_PROG, OP_PAGE: allow_c = pgm_ok || dat_ok;
      OP_MASS:          allow_c = pgm_all;
      default:          allow_c = 1'b0;
    endcase
    viol_set = req_valid && !allow_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      done_q  <= req_valid;
      grant_q <= req_valid && allow_c;
    end
  end

  assign done  = done_q;
  assign grant = grant_q;

  // R6: one done per strobe, grant only alongside done
  a_r6_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> done_q);
  a_r6_grant_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    grant_q |-> done_q);
  // R5: mass erase blocked unless every program section is open
  a_r5_mass_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == OP_MASS && !pgm_all |=> !grant_q);
  // R4: the idle operation code never gets through
  a_r4_none_denied: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == OP_NONE |=> !grant_q);

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int                ADDR_W       = 24,
  parameter int                DATA_W       = 16,
  parameter int                SEC_CNT      = 16,
  parameter int                PGM_SEC_LOG2 = 13,
  parameter logic [ADDR_W-1:0] PGM_BASE     = 24'h020000,
  parameter int                DAT_SEC_LOG2 = 9,
  parameter logic [ADDR_W-1:0] DAT_BASE     = 24'h0D0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_sel,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              flash_busy,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_done,
  output logic              req_grant,
  output logic              prot_fault
);

  logic [1:0]         rst_sync_q;
  logic               rst_s_n;
  logic [SEC_CNT-1:0] pgm_we, dat_we;
  logic               pgm_hit, pgm_ok, dat_hit, dat_ok, viol_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  flash_guard_regs #(.SEC_CNT(SEC_CNT), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_s_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .flash_busy(flash_busy), .viol_set(viol_set),
    .pgm_we(pgm_we), .dat_we(dat_we), .viol(prot_fault)
  );

  flash_guard_decode #(.ADDR_W(ADDR_W), .SEC_CNT(SEC_CNT),
                       .SEC_LOG2(PGM_SEC_LOG2), .BASE(PGM_BASE)) pgm_dec_i (
    .addr(req_addr), .sec_we(pgm_we), .hit(pgm_hit), .allowed(pgm_ok)
  );

  flash_guard_decode #(.ADDR_W(ADDR_W), .SEC_CNT(SEC_CNT),
                       .SEC_LOG2(DAT_SEC_LOG2), .BASE(DAT_BASE)) dat_dec_i (
    .addr(req_addr), .sec_we(dat_we), .hit(dat_hit), .allowed(dat_ok)
  );

  flash_guard_arb arb_i (
    .clk(clk), .rst_n(rst_s_n),
    .req_valid(req_valid), .req_kind(req_kind),
    .pgm_ok(pgm_ok), .dat_ok(dat_ok), .pgm_all(&pgm_we),
    .viol_set(viol_set), .done(req_done), .grant(req_grant)
  );

  // R4: the two windows never overlap
  a_r4_regions_disjoint: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(pgm_hit && dat_hit));
  // R7: a denied strobe leaves the fault flag raised
  a_r7_deny_flags: assert property (@(posedge clk) disable iff (!rst_s_n)
    req_done && !req_grant |-> prot_fault);

endmodule

// File: tb/flash_guard_tb.sv
module flash_guard_tb_top;

  typedef struct packed {
    logic [23:0] addr;
    logic [1:0]  kind;
    logic        exp;
  } vec_t;

  // enables in force: program 16'h8001, data 16'h0010
  localparam vec_t VECS [0:13] = '{
    '{24'h020000, 2'd0, 1'b1},  // R2 first section, first byte
    '{24'h021FFF, 2'd0, 1'b1},  // R2 first section, last byte
    '{24'h022000, 2'd0, 1'b0},  // R2 section 1 closed
    '{24'h03E000, 2'd1, 1'b1},  // R2 last section
    '{24'h03FFFF, 2'd0, 1'b1},  // R2 window top
    '{24'h01FFFF, 2'd0, 1'b0},  // R4 below program window
    '{24'h040000, 2'd1, 1'b0},  // R4 above program window
    '{24'h0D0800, 2'd1, 1'b1},  // R3 data section 4
    '{24'h0D09FF, 2'd0, 1'b1},  // R3 data section 4 top
    '{24'h0D0A00, 2'd1, 1'b0},  // R3 data section 5 closed
    '{24'h0D0000, 2'd0, 1'b0},  // R3 data section 0 closed
    '{24'h0D2000, 2'd0, 1'b0},  // R4 above data window
    '{24'h020000, 2'd3, 1'b0},  // R4 code 3 denied
    '{24'h020000, 2'd2, 1'b0}   // R5 mass erase with partial enables
  };

  logic        clk, rst_n;
  logic [1:0]  bus_sel;
  logic        bus_wr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        flash_busy, req_valid;
  logic [1:0]  req_kind;
  logic [23:0] req_addr;
  logic        req_done, req_grant, prot_fault;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  flash_guard dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flash_busy(flash_busy),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .req_done(req_done), .req_grant(req_grant), .prot_fault(prot_fault)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    bus_sel = sel; bus_wr = 1'b1; bus_wdata = data;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input string req, input logic [1:0] sel, input logic [15:0] exp);
    @(negedge clk);
    bus_sel = sel;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic request(input string req, input logic [1:0] kind,
                         input logic [23:0] addr, input logic exp);
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " done"}, {15'd0, req_done}, 16'd1);
    check({req, " grant"}, {15'd0, req_grant}, {15'd0, exp});
    @(negedge clk);
    check({req, " done drop"}, {15'd0, req_done}, 16'd0);
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 2'd0; bus_wr = 1'b0; bus_wdata = '0;
    flash_busy = 1'b0; req_valid = 1'b0; req_kind = 2'd0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_read("R1 pgm", 2'd0, 16'h0000);
    bus_read("R1 dat", 2'd1, 16'h0000);
    bus_read("R1 ctrl", 2'd2, 16'h0000);
    bus_read("R1 stat", 2'd3, 16'h0000);
    request("R1 locked program", 2'd0, 24'h020000, 1'b0);
    request("R1 locked data", 2'd1, 24'h0D0000, 1'b0);
    check("R7 flag set", {15'd0, prot_fault}, 16'd1);
    bus_write(2'd3, 16'h0001);
    bus_read("R7 flag cleared", 2'd3, 16'h0000);

    // R8 register read-back
    bus_write(2'd0, 16'h8001);
    bus_write(2'd1, 16'h0010);
    bus_read("R8 pgm", 2'd0, 16'h8001);
    bus_read("R8 dat", 2'd1, 16'h0010);

    for (int i = 0; i < 14; i++) begin
      request($sformatf("vec%0d", i), VECS[i].kind, VECS[i].addr, VECS[i].exp);
    end
    bus_read("R7 sticky after denials", 2'd3, 16'h0001);
    bus_write(2'd3, 16'h0000);
    bus_read("R7 write 0 keeps flag", 2'd3, 16'h0001);

    // R7 denial and clear in same cycle: set wins
    @(negedge clk);
    bus_sel = 2'd3; bus_wr = 1'b1; bus_wdata = 16'h0001;
    req_valid = 1'b1; req_kind = 2'd3; req_addr = '0;
    @(negedge clk);
    bus_wr = 1'b0; req_valid = 1'b0;
    check("R7 set beats clear", {15'd0, prot_fault}, 16'd1);
    bus_write(2'd3, 16'h0001);
    bus_read("R7 cleared", 2'd3, 16'h0000);

    // R5 mass erase when fully open, address outside windows
    bus_write(2'd0, 16'hFFFF);
    request("R5 mass open", 2'd2, 24'hFFFFFF, 1'b1);
    request("R2 section 1 now open", 2'd0, 24'h022000, 1'b1);
    bus_write(2'd0, 16'h7FFF);
    request("R5 mass one closed", 2'd2, 24'h020000, 1'b0);
    bus_read("R6 grants leave flag", 2'd3, 16'h0001);

    // R9 reserved bits, R10 low-power lock
    bus_write(2'd2, 16'hFFFF);
    bus_read("R9 reserved zero", 2'd2, 16'h00DD);
    flash_busy = 1'b1;
    bus_write(2'd2, 16'h0000);
    bus_read("R10 lp held busy", 2'd2, 16'h0001);
    flash_busy = 1'b0;
    bus_write(2'd2, 16'h0000);
    bus_read("R10 lp clears idle", 2'd2, 16'h0000);
    flash_busy = 1'b1;
    bus_write(2'd2, 16'h0011);
    bus_read("R10 lp not set busy", 2'd2, 16'h0010);
    flash_busy = 1'b0;

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule